// File: doc/BRIEF.md
# Vector Modified Immediate Expander

This block turns an 8-bit immediate into a 64-bit constant that a vector datapath can use as a move or logical operand. A 4-bit mode selector and a negate flag choose how the immediate is placed. It can be a byte shifted into 32-bit or 16-bit lanes. It can be a byte shifted up with ones filled in below it. It can be copied into every byte, or used as a mask in which each immediate bit picks a whole byte. It can also be read as a compact floating-point constant and widened to a single-precision or a double-precision value. The block has no clock and no state. Its result depends only on the three inputs in the same cycle.

A decoder places the block right after instruction field extraction. The block also reports when a mode/negate pairing is not supported by the configuration. The parameter `DP_EN` selects whether the double-precision form is legal. When it is cleared, that pairing raises the illegal flag and returns zero.

Top module: `vmi_expand`

## Requirements
- R1: For mode[3:1] in 0..3, every 32-bit lane of the result holds the immediate shifted left by 8*mode[3:1] bits, and all other lane bits are zero.
- R2: For mode[3:1] of 4 or 5, every 16-bit lane holds the immediate shifted left by 8*mode[1] bits, and all other lane bits are zero.
- R3: For mode[3:1] equal to 6, every 32-bit lane holds the immediate shifted left by 8 with eight ones below it when mode[0]=0, or shifted left by 16 with sixteen ones below it when mode[0]=1.
- R4: Mode 1110 with negate=0 copies the immediate into all eight bytes.
- R5: Mode 1110 with negate=1 makes byte i equal 0xFF when immediate bit i is 1, and 0x00 when it is 0.
- R6: Mode 1111 with negate=0 places a 32-bit float in each half. Bit 31 is imm[7]. Bit 30 is the inverse of imm[6]. Bits 29:25 are copies of imm[6]. Bits 24:19 are imm[5:0]. Bits 18:0 are zero.
- R7: Mode 1111 with negate=1, when `DP_EN`=1, gives a 64-bit float. Bit 63 is imm[7]. Bit 62 is the inverse of imm[6]. Bits 61:54 are copies of imm[6]. Bits 53:48 are imm[5:0]. Bits 47:0 are zero.
- R8: For any mode with mode[3:1] not equal to 7, negate=1 returns the bitwise inverse of the pattern that negate=0 gives.
- R9: With `DP_EN`=0, mode 1111 with negate=1 sets the illegal flag and forces the value to zero. With `DP_EN`=1, the illegal flag is never set.
- R10: For mode[3] = 0 and for mode[3:1] of 4 or 5, mode[0] has no effect on the value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| imm8 | input | 8 | Immediate byte to expand |
| cmode | input | 4 | Placement mode selector |
| op | input | 1 | Negate / alternate-form flag |
| value | output | 64 | Expanded constant |
| illegal | output | 1 | Unsupported mode/negate pairing |

## Verification
The hardest corner to reach is the illegal pairing. It only exists when double precision is disabled, so the default build can never show it. The bench therefore runs a second instance with `DP_EN` cleared and the same inputs. For every immediate, it checks that this instance flags the pairing and returns zero. Meanwhile, the default instance produces the double-precision constant. The bench walks every immediate, mode and negate combination on both instances. It also drives mode pairs that differ only in mode[0] and compares the two outputs directly, to show that bit 0 is ignored.

// File: rtl/vmi_pkg.sv
`timescale 1ns/1ps
package vmi_pkg;
   localparam int IMM_W    = 8;
   localparam int MODE_W   = 4;
   localparam int WORD_W   = 64;
   localparam int BYTE_W   = 8;
   localparam int SP_W     = 32;
   localparam int SP_EXP_W = 8;
   localparam int DP_W     = 64;
   localparam int DP_EXP_W = 11;

   typedef enum logic [2:0] {
      GRP_W32_B0 = 3'd0,
      GRP_W32_B1 = 3'd1,
      GRP_W32_B2 = 3'd2,
      GRP_W32_B3 = 3'd3,
      GRP_H16_B0 = 3'd4,
      GRP_H16_B1 = 3'd5,
      GRP_ONES   = 3'd6,
      GRP_MISC   = 3'd7
   } mode_grp_e;
endpackage

// File: rtl/vmi_lane_gen.sv
`timescale 1ns/1ps
module vmi_lane_gen #(
   parameter int  LANE_W  = 32,
   parameter int  OUT_W   = 64,
   parameter bit  ONES_EN = 1'b0,
   localparam int SEL_W   = $clog2(LANE_W / 8),
   localparam int REPS    = OUT_W / LANE_W
) (
   input  logic [7:0]        imm8,
   input  logic [SEL_W-1:0]  byte_sel,
   output logic [OUT_W-1:0]  pattern
);
   if (LANE_W % 8 != 0 || LANE_W < 16) begin : g_bad_lane
      $error("vmi_lane_gen: LANE_W must be a multiple of 8 and at least 16");
   end
   if (OUT_W % LANE_W != 0) begin : g_bad_out
      $error("vmi_lane_gen: OUT_W must be a multiple of LANE_W");
   end

   logic [LANE_W-1:0] imm_ext;
   logic [LANE_W-1:0] shifted;
   logic [LANE_W-1:0] lane;

   assign imm_ext = {{(LANE_W-8){1'b0}}, imm8};

   always_comb begin
      shifted = imm_ext << (8 * int'(byte_sel));
   end

   if (ONES_EN) begin : g_ones
      logic [LANE_W-1:0] low_fill;
      always_comb begin
         low_fill = ~({LANE_W{1'b1}} << (8 * int'(byte_sel)));
      end
      assign lane = shifted | low_fill;
   end else begin : g_zero
      assign lane = shifted;
   end

   for (genvar r = 0; r < REPS; r++) begin : g_rep
      assign pattern[r*LANE_W +: LANE_W] = lane;
   end
endmodule

// File: rtl/vmi_byte_gen.sv
`timescale 1ns/1ps
module vmi_byte_gen #(
   parameter int  OUT_W  = 64,
   localparam int NBYTES = OUT_W / 8
) (
   input  logic [7:0]       imm8,
   output logic [OUT_W-1:0] splat,
   output logic [OUT_W-1:0] mask
);
   if (OUT_W != 64) begin : g_bad_w
      $error("vmi_byte_gen: one byte per immediate bit needs OUT_W of 64");
   end

   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign splat[b*8 +: 8] = imm8;
      assign mask[b*8 +: 8]  = {8{imm8[b]}};
   end
endmodule

// File: rtl/vmi_fp_gen.sv
`timescale 1ns/1ps
module vmi_fp_gen #(
   parameter int  FP_W   = 32,
   parameter int  EXP_W  = 8,
   parameter int  OUT_W  = 64,
   localparam int REPL_W = EXP_W - 3,
   localparam int TAIL_W = FP_W - EXP_W - 5,
   localparam int REPS   = OUT_W / FP_W
) (
   input  logic [7:0]       imm8,
   output logic [OUT_W-1:0] pattern
);
   if (EXP_W < 4 || TAIL_W < 1) begin : g_bad_fmt
      $error("vmi_fp_gen: format too narrow for an 8-bit immediate");
   end
   if (OUT_W % FP_W != 0) begin : g_bad_out
      $error("vmi_fp_gen: OUT_W must be a multiple of FP_W");
   end

   logic [FP_W-1:0] word;

   assign word = {imm8[7], ~imm8[6], {REPL_W{imm8[6]}}, imm8[5:0], {TAIL_W{1'b0}}};

   for (genvar r = 0; r < REPS; r++) begin : g_rep
      assign pattern[r*FP_W +: FP_W] = word;
   end
endmodule

// File: rtl/vmi_expand.sv
`timescale 1ns/1ps
module vmi_expand #(
   parameter bit DP_EN = 1'b1
) (
   input  logic [vmi_pkg::IMM_W-1:0]  imm8,
   input  logic [vmi_pkg::MODE_W-1:0] cmode,
   input  logic                       op,
   output logic [vmi_pkg::WORD_W-1:0] value,
   output logic                       illegal
);
   import vmi_pkg::*;

   if (IMM_W != 8 || MODE_W != 4) begin : g_bad_fields
      $error("vmi_expand: field widths are fixed at 8 and 4");
   end

   mode_grp_e         grp;
   logic [WORD_W-1:0] w32_pat, h16_pat, ones_pat;
   logic [WORD_W-1:0] splat_pat, mask_pat, sp_pat, dp_pat;
   logic [WORD_W-1:0] base, misc;
   logic [1:0]        ones_sel;
   logic              bad_pair;

   assign grp      = mode_grp_e'(cmode[3:1]);
   assign ones_sel = cmode[0] ? 2'd2 : 2'd1;

   vmi_lane_gen #(.LANE_W(32), .OUT_W(WORD_W), .ONES_EN(1'b0)) u_w32 (
      .imm8(imm8), .byte_sel(cmode[2:1]), .pattern(w32_pat));

   vmi_lane_gen #(.LANE_W(16), .OUT_W(WORD_W), .ONES_EN(1'b0)) u_h16 (
      .imm8(imm8), .byte_sel(cmode[1]), .pattern(h16_pat));

   vmi_lane_gen #(.LANE_W(32), .OUT_W(WORD_W), .ONES_EN(1'b1)) u_ones (
      .imm8(imm8), .byte_sel(ones_sel), .pattern(ones_pat));

   vmi_byte_gen #(.OUT_W(WORD_W)) u_bytes (
      .imm8(imm8), .splat(splat_pat), .mask(mask_pat));

   vmi_fp_gen #(.FP_W(SP_W), .EXP_W(SP_EXP_W), .OUT_W(WORD_W)) u_sp (
      .imm8(imm8), .pattern(sp_pat));

   if (DP_EN) begin : g_dp
      vmi_fp_gen #(.FP_W(DP_W), .EXP_W(DP_EXP_W), .OUT_W(WORD_W)) u_dp (
         .imm8(imm8), .pattern(dp_pat));
      assign bad_pair = 1'b0;
   end else begin : g_no_dp
      assign dp_pat   = '0;
      assign bad_pair = (cmode == 4'b1111) && op;
   end

   always_comb begin
      unique case ({cmode[0], op})
         2'b00:   misc = splat_pat;
         2'b01:   misc = mask_pat;
         2'b10:   misc = sp_pat;
         default: misc = dp_pat;
      endcase
   end

   always_comb begin
      unique case (grp)
         GRP_W32_B0, GRP_W32_B1,
         GRP_W32_B2, GRP_W32_B3: base = w32_pat;
         GRP_H16_B0, GRP_H16_B1: base = h16_pat;
         GRP_ONES:               base = ones_pat;
         default:                base = misc;
      endcase
   end

   always_comb begin
      if (bad_pair) begin
         value = '0;
      end else if (grp != GRP_MISC && op) begin
         value = ~base;
      end else begin
         value = base;
      end
   end

   assign illegal = bad_pair;
endmodule

// File: rtl/vmi_expand_chk.sv
`timescale 1ns/1ps
module vmi_expand_chk #(
   parameter bit DP_EN = 1'b1
) (
   input logic [7:0]  imm8,
   input logic [3:0]  cmode,
   input logic        op,
   input logic [63:0] value,
   input logic        illegal
);
   always_comb begin
      if (cmode[3] == 1'b0 && !op) begin
         p_half_repeat_r1: assert (value[63:32] == value[31:0])
            else $error("32-bit lanes differ");
      end
      if (cmode[3:2] == 2'b10) begin
         p_quarter_repeat_r2: assert (value[15:0] == value[47:32])
            else $error("16-bit lanes differ");
      end
      if (cmode == 4'b1101 && !op) begin
         p_ones_fill_r3: assert (value[15:0] == 16'hFFFF)
            else $error("low ones missing");
      end
      if (cmode == 4'b1110 && op) begin
         p_mask_byte_r5: assert (value[7:0] == {8{imm8[0]}} && value[63:56] == {8{imm8[7]}})
            else $error("byte mask wrong");
      end
      if (cmode == 4'b1111 && !op) begin
         p_sp_sign_r6: assert (value[31] == imm8[7] && value[63] == imm8[7])
            else $error("sign bit wrong");
      end
      if (cmode == 4'b0000 && op) begin
         p_invert_high_r8: assert (value[31:8] == 24'hFFFFFF)
            else $error("inversion missing");
      end
      if (illegal) begin
         p_illegal_zero_r9: assert (value == 64'd0 && !DP_EN)
            else $error("illegal result not zero");
      end
   end
endmodule

bind vmi_expand vmi_expand_chk #(.DP_EN(DP_EN)) chk_i (
   .imm8(imm8), .cmode(cmode), .op(op), .value(value), .illegal(illegal));

// File: tb/vmi_expand_tb.sv
`timescale 1ns/1ps
module vmi_expand_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  imm8 = '0;
   logic [3:0]  cmode = '0;
   logic        op = 1'b0;
   logic [63:0] value, value_nd;
   logic        illegal, illegal_nd;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   vmi_expand dut_i (.imm8(imm8), .cmode(cmode), .op(op), .value(value), .illegal(illegal));
   vmi_expand #(.DP_EN(1'b0)) dut_nodp_i (.imm8(imm8), .cmode(cmode), .op(op),
      .value(value_nd), .illegal(illegal_nd));

   function automatic string req_tag(input int c, input bit o);
      if (c < 8)   return o ? "R1/R8" : "R1";
      if (c < 12)  return o ? "R2/R8" : "R2";
      if (c < 14)  return o ? "R3/R8" : "R3";
      if (c == 14) return o ? "R5" : "R4";
      return o ? "R7" : "R6";
   endfunction

   function automatic logic [63:0] ref_val(input int im, input int c, input bit o);
      logic [63:0] r;
      logic [31:0] w;
      logic [15:0] h;
      r = '0;
      if (c < 8) begin
         w = 32'(im) << (8 * (c / 2));
         r = {w, w};
      end else if (c < 12) begin
         h = 16'(im) << (8 * ((c / 2) % 2));
         r = {h, h, h, h};
      end else if (c == 12) begin
         w = (32'(im) << 8) | 32'h0000_00FF;
         r = {w, w};
      end else if (c == 13) begin
         w = (32'(im) << 16) | 32'h0000_FFFF;
         r = {w, w};
      end else if (c == 14) begin
         for (int k = 0; k < 8; k++)
            r[k*8 +: 8] = o ? ((im >> k) % 2 == 1 ? 8'hFF : 8'h00) : 8'(im);
      end else if (!o) begin
         w = '0;
         w[31] = im[7];
         w[30] = ~im[6];
         for (int k = 25; k <= 29; k++) w[k] = im[6];
         w[24:19] = 6'(im);
         r = {w, w};
      end else begin
         r[63] = im[7];
         r[62] = ~im[6];
         for (int k = 54; k <= 61; k++) r[k] = im[6];
         r[53:48] = 6'(im);
      end
      if (c < 14 && o) r = ~r;
      return r;
   endfunction

   task automatic check64(input string tag, input string who, input logic [63:0] act,
                          input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s imm=%02h mode=%0d op=%0b act=%016h exp=%016h",
                  tag, who, imm8, cmode, op, act, exp);
      end
   endtask

   task automatic check1(input string tag, input string who, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s imm=%02h mode=%0d op=%0b act=%0b exp=%0b",
                  tag, who, imm8, cmode, op, act, exp);
      end
   endtask

   task automatic apply(input int im, input int c, input bit o);
      @(negedge clk);
      imm8  = 8'(im);
      cmode = 4'(c);
      op    = o;
      @(posedge clk);
      #1;
   endtask

   initial begin
      logic [63:0] held;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      apply(0, 0, 1'b0);
      check64("R1", "reset-zero", value, 64'd0);
      check1("R9", "reset-flag", illegal, 1'b0);

      for (int c = 0; c < 16; c++)
         for (int o = 0; o < 2; o++)
            for (int im = 0; im < 256; im++) begin
               apply(im, c, o[0]);
               check64(req_tag(c, o[0]), "dp", value, ref_val(im, c, o[0]));
               check1("R9", "dp-flag", illegal, 1'b0);
               if (c == 15 && o == 1) begin
                  check64("R9", "nodp", value_nd, 64'd0);
                  check1("R9", "nodp-flag", illegal_nd, 1'b1);
               end else begin
                  check64(req_tag(c, o[0]), "nodp", value_nd, ref_val(im, c, o[0]));
                  check1("R9", "nodp-flag", illegal_nd, 1'b0);
               end
            end

      // R10: mode[0] ignored for shifted-byte groups
      for (int c = 0; c < 12; c += 2)
         for (int o = 0; o < 2; o++) begin
            apply(8'hA5, c, o[0]);
            held = value;
            apply(8'hA5, c + 1, o[0]);
            check64("R10", "bit0", value, held);
         end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule